// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Slice

This block compares two unsigned words of four bits each and reports exactly one relation: greater, equal or less. It has no clock and no storage, so its outputs follow its inputs within the same cycle. It also takes three relation inputs from a less significant slice of the same kind. These inputs settle the result only when every local bit pair matches. A local difference always wins over them.

To build a wider comparator, place slices in series. The outputs of each slice drive the relation inputs of the next more significant slice. The least significant slice takes the constant relation "equal" (greater low, equal high, less low). The most significant slice then gives the relation of the full words. Two slices compare 8-bit words, and any multiple of four bits is built the same way. The local word width is a parameter, with a default of 4.

There are no states or transitions. The only "state" is the combinational relation carried along the chain.

Top module: `magcmp_stage`

## Requirements
- R1: `eq_o` is 1 exactly when every bit of `a_i` equals the matching bit of `b_i` and `cas_eq_i` is 1.
- R2: `gt_o` is 1 whenever `a_i` is greater than `b_i` as an unsigned number. The deciding bit is the most significant position where they differ, with `a_i` holding 1 there.
- R3: `lt_o` is 1 whenever `a_i` is less than `b_i` as an unsigned number. The deciding bit is the most significant position where they differ, with `b_i` holding 1 there.
- R4: When `a_i` equals `b_i`, the output triple {`gt_o`,`eq_o`,`lt_o`} equals the input triple {`cas_gt_i`,`cas_eq_i`,`cas_lt_i`}.
- R5: When `a_i` differs from `b_i`, the relation inputs have no effect. The outputs are 1,0,0 for greater and 0,0,1 for less, whatever the relation inputs are.
- R6: When exactly one of the three relation inputs is 1, exactly one of the three outputs is 1.
- R7: A series chain, with the least significant slice tied to greater=0, equal=1, less=0 and each slice's outputs feeding the next slice's relation inputs, reports the unsigned relation of the concatenated words.
- R8: The outputs are purely combinational. They reflect new inputs in the same cycle, with no clock or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand, unsigned |
| b_i | input | 4 | Second operand, unsigned |
| cas_gt_i | input | 1 | Greater relation from the less significant slice |
| cas_eq_i | input | 1 | Equal relation from the less significant slice |
| cas_lt_i | input | 1 | Less relation from the less significant slice |
| gt_o | output | 1 | First operand greater |
| eq_o | output | 1 | Operands equal |
| lt_o | output | 1 | First operand less |

## Verification
A wrong prefix-equality term would let a lower differing bit override a higher one. That shows at the ports as a reversed greater/less result for operand pairs that differ in more than one bit. A wrong relation path would show as a lost or doubled output only when the local words match. Because the logic holds no state, any such fault is visible in the same cycle as the input pattern that exposes it. It is also visible at the top of a chain as soon as the faulty slice's relation propagates upward.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    // Relation triple carried between slices
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    localparam rel_t REL_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/magcmp_bitmatch.sv
// Per-bit match terms (XNOR of each operand pair)
module magcmp_bitmatch #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] match_o
);

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        assign match_o[k] = ~(a_i[k] ^ b_i[k]);
    end

endmodule

// File: rtl/magcmp_prefix.sv
// Prefix-equality products and the local greater/less/equal decision
module magcmp_prefix #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] match_i,
    output logic             loc_gt_o,
    output logic             loc_lt_o,
    output logic             all_eq_o
);

    // upper_eq[k]: every bit pair above position k matches
    logic [WIDTH-1:0] upper_eq;

    always_comb begin
        upper_eq[WIDTH-1] = 1'b1;
        for (int k = WIDTH - 2; k >= 0; k--) begin
            upper_eq[k] = upper_eq[k+1] & match_i[k+1];
        end
    end

    assign loc_gt_o = |(a_i & ~b_i & upper_eq);
    assign loc_lt_o = |(~a_i & b_i & upper_eq);
    assign all_eq_o = &match_i;

endmodule

// File: rtl/magcmp_resolve.sv
// Merges the local decision with the relation from the lower slice
module magcmp_resolve
    import magcmp_pkg::*;
(
    input  logic loc_gt_i,
    input  logic loc_lt_i,
    input  logic all_eq_i,
    input  rel_t low_i,
    output rel_t rel_o
);

    always_comb begin
        rel_o.gt = loc_gt_i | (all_eq_i & low_i.gt);
        rel_o.eq = all_eq_i & low_i.eq;
        rel_o.lt = loc_lt_i | (all_eq_i & low_i.lt);
    end

endmodule

// File: rtl/magcmp_stage.sv
module magcmp_stage
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cas_gt_i,
    input  logic             cas_eq_i,
    input  logic             cas_lt_i,
    output logic             gt_o,
    output logic             eq_o,
    output logic             lt_o
);

    logic [WIDTH-1:0] match;
    logic             loc_gt;
    logic             loc_lt;
    logic             all_eq;
    rel_t             low_rel;
    rel_t             out_rel;

    assign low_rel = '{gt: cas_gt_i, eq: cas_eq_i, lt: cas_lt_i};

    magcmp_bitmatch #(.WIDTH(WIDTH)) u_match (
        .a_i     (a_i),
        .b_i     (b_i),
        .match_o (match)
    );

    magcmp_prefix #(.WIDTH(WIDTH)) u_prefix (
        .a_i      (a_i),
        .b_i      (b_i),
        .match_i  (match),
        .loc_gt_o (loc_gt),
        .loc_lt_o (loc_lt),
        .all_eq_o (all_eq)
    );

    magcmp_resolve u_resolve (
        .loc_gt_i (loc_gt),
        .loc_lt_i (loc_lt),
        .all_eq_i (all_eq),
        .low_i    (low_rel),
        .rel_o    (out_rel)
    );

    assign gt_o = out_rel.gt;
    assign eq_o = out_rel.eq;
    assign lt_o = out_rel.lt;

endmodule

// File: rtl/magcmp_stage_chk.sv
module magcmp_stage_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cas_gt_i,
    input logic             cas_eq_i,
    input logic             cas_lt_i,
    input logic             gt_o,
    input logic             eq_o,
    input logic             lt_o
);

    always_comb begin
        // R1
        eq_out_chk: assert (!eq_o || ((a_i == b_i) && cas_eq_i))
            else $error("eq_o without matching words and equal relation");
        // R2
        gt_local_chk: assert (!(a_i > b_i) || (gt_o && !eq_o && !lt_o))
            else $error("greater operand not reported");
        // R3
        lt_local_chk: assert (!(a_i < b_i) || (lt_o && !eq_o && !gt_o))
            else $error("lesser operand not reported");
        // R4
        pass_chk: assert ((a_i != b_i) || ({gt_o, eq_o, lt_o} == {cas_gt_i, cas_eq_i, cas_lt_i}))
            else $error("relation inputs not passed on equal words");
        // R6
        onehot_out_chk: assert (!$onehot({cas_gt_i, cas_eq_i, cas_lt_i}) || $onehot({gt_o, eq_o, lt_o}))
            else $error("outputs not one-hot");
    end

endmodule

bind magcmp_stage magcmp_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .cas_gt_i (cas_gt_i),
    .cas_eq_i (cas_eq_i),
    .cas_lt_i (cas_lt_i),
    .gt_o     (gt_o),
    .eq_o     (eq_o),
    .lt_o     (lt_o)
);

// File: tb/sim_magcmp_stage.sv
module magcmp_chain #(
    parameter int STAGES = 2,
    parameter int SLICE  = 4,
    localparam int TOTAL = STAGES * SLICE
) (
    input  logic [TOTAL-1:0] a_i,
    input  logic [TOTAL-1:0] b_i,
    output logic             gt_o,
    output logic             eq_o,
    output logic             lt_o
);

    logic [STAGES:0] gt_c;
    logic [STAGES:0] eq_c;
    logic [STAGES:0] lt_c;

    assign gt_c[0] = 1'b0;
    assign eq_c[0] = 1'b1;
    assign lt_c[0] = 1'b0;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        magcmp_stage #(.WIDTH(SLICE)) u_st (
            .a_i      (a_i[s*SLICE +: SLICE]),
            .b_i      (b_i[s*SLICE +: SLICE]),
            .cas_gt_i (gt_c[s]),
            .cas_eq_i (eq_c[s]),
            .cas_lt_i (lt_c[s]),
            .gt_o     (gt_c[s+1]),
            .eq_o     (eq_c[s+1]),
            .lt_o     (lt_c[s+1])
        );
    end

    assign gt_o = gt_c[STAGES];
    assign eq_o = eq_c[STAGES];
    assign lt_o = lt_c[STAGES];

endmodule

module sim_magcmp_stage;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // single slice
    logic [3:0] a, b;
    logic       cgt, ceq, clt;
    logic       gt, eq, lt;

    magcmp_stage #(.WIDTH(4)) u0 (
        .a_i(a), .b_i(b), .cas_gt_i(cgt), .cas_eq_i(ceq), .cas_lt_i(clt),
        .gt_o(gt), .eq_o(eq), .lt_o(lt)
    );

    // 8-bit chain
    logic [7:0] a8, b8;
    logic       gt8, eq8, lt8;
    magcmp_chain #(.STAGES(2)) u_c8 (
        .a_i(a8), .b_i(b8), .gt_o(gt8), .eq_o(eq8), .lt_o(lt8)
    );

    // 32-bit chain
    logic [31:0] a32, b32;
    logic        gt32, eq32, lt32;
    magcmp_chain #(.STAGES(8)) u_c32 (
        .a_i(a32), .b_i(b32), .gt_o(gt32), .eq_o(eq32), .lt_o(lt32)
    );

    function automatic logic [2:0] model(longint unsigned x, longint unsigned y, logic [2:0] low);
        if (x > y)  return 3'b100;
        if (x < y)  return 3'b001;
        return low;
    endfunction

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got {gt,eq,lt}=%b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        #2;
    endtask

    // R8 R1: tied-off idle pattern
    task automatic t_idle();
        a = 4'd0; b = 4'd0; {cgt, ceq, clt} = 3'b010;
        settle();
        chk("R8", {gt, eq, lt}, 3'b010);
        a = 4'd9; b = 4'd9;
        settle();
        chk("R1", {gt, eq, lt}, 3'b010);
        a = 4'd3;
        settle();
        chk("R8", {gt, eq, lt}, 3'b001);
    endtask

    // R2 R3 R5: most significant differing bit decides
    task automatic t_msb_priority();
        a = 4'b1000; b = 4'b0111; {cgt, ceq, clt} = 3'b001;
        settle();
        chk("R2", {gt, eq, lt}, 3'b100);
        a = 4'b0111; b = 4'b1000; {cgt, ceq, clt} = 3'b100;
        settle();
        chk("R3", {gt, eq, lt}, 3'b001);
        a = 4'b1101; b = 4'b1011; {cgt, ceq, clt} = 3'b010;
        settle();
        chk("R5", {gt, eq, lt}, 3'b100);
        a = 4'b0010; b = 4'b0011; {cgt, ceq, clt} = 3'b100;
        settle();
        chk("R5", {gt, eq, lt}, 3'b001);
    endtask

    // R4: equal words forward each legal relation
    task automatic t_passthrough();
        for (int v = 0; v < 16; v += 5) begin
            a = 4'(v); b = 4'(v);
            {cgt, ceq, clt} = 3'b100; settle(); chk("R4", {gt, eq, lt}, 3'b100);
            {cgt, ceq, clt} = 3'b010; settle(); chk("R4", {gt, eq, lt}, 3'b010);
            {cgt, ceq, clt} = 3'b001; settle(); chk("R4", {gt, eq, lt}, 3'b001);
        end
    endtask

    // R1 R2 R3 R4 R5 R6: every operand pair with every legal relation
    task automatic t_exhaustive_slice();
        logic [2:0] lows [3] = '{3'b100, 3'b010, 3'b001};
        for (int r = 0; r < 3; r++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    a = 4'(x); b = 4'(y); {cgt, ceq, clt} = lows[r];
                    settle();
                    chk("R6", {gt, eq, lt}, model(longint'(x), longint'(y), lows[r]));
                end
            end
        end
    endtask

    // R7: 8-bit chain, all pairs
    task automatic t_chain8();
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                a8 = 8'(x); b8 = 8'(y);
                settle();
                chk("R7", {gt8, eq8, lt8}, model(longint'(x), longint'(y), 3'b010));
            end
        end
    endtask

    // R7: 32-bit chain, random and near-equal words
    task automatic t_chain32();
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] x, y;
            x = $urandom;
            case (n % 3)
                0: y = $urandom;
                1: y = x ^ (32'd1 << ($urandom % 32));
                default: y = x;
            endcase
            a32 = x; b32 = y;
            settle();
            chk("R7", {gt32, eq32, lt32}, model(longint'(x), longint'(y), 3'b010));
        end
    endtask

    initial begin
        a = '0; b = '0; {cgt, ceq, clt} = 3'b010;
        a8 = '0; b8 = '0; a32 = '0; b32 = '0;
        @(posedge clk);
        #1;
        t_idle();
        t_msb_priority();
        t_passthrough();
        t_exhaustive_slice();
        t_chain8();
        t_chain32();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule